// File: doc/BRIEF.md
# Match-Guided Literal Byte Decoder

This block recovers one 8-bit literal from a range-coded stream. It does not do the range arithmetic itself. It asks an external binary decoder core for eight adaptive bits, one after another. For each bit it picks the probability word that the core should use, and it writes the adapted probability back. The probability words live in an external memory. Each literal owns a set of 0x300 words that starts at a base address given with the start pulse.

In guided mode, a reference byte from earlier output steers the choice of probability. While every decoded bit still equals the matching bit of the reference byte, a 0x100 offset mask keeps the index in one of two upper sub-tables. The choice of sub-table depends on the reference bit. The first disagreement clears the mask for good, and the remaining bits use the plain tree. In plain mode the mask is zero from the start, so the block walks an ordinary 8-level forward tree.

The caller pulses start with the mode, the reference byte and the base. It then waits for the one-cycle done pulse, which carries the byte.

Top module: `mlit_decoder`

## Requirements
- R1: After reset the block is idle: bit_req, prob_we and done are all low.
- R2: start is taken only while idle. It latches guided, match_byte and base. A start while a literal is in progress has no effect on that literal's indices, writes or result.
- R3: In guided mode, bit k (k = 0 first) reads the match-byte bit at position 7-k (MSB first). The request index is base + offset + match_term + symbol. The term match_term is 0x100 when the offset is 0x100 and that match-byte bit is 1, and 0 otherwise. The index always stays below base + 0x300.
- R4: The offset starts at 0x100 in guided mode. It becomes 0 after the first decoded bit that differs from the match-byte bit, and it stays 0 for the rest of that literal.
- R5: In plain mode (guided = 0) the index is base + symbol for all eight bits, whatever match_byte holds.
- R6: The symbol starts at 1 and becomes 2*symbol + bit on each accepted bit. A literal takes exactly eight accepted bits. byte_out is the low 8 bits of the final symbol, so it holds the decoded bits MSB first.
- R7: In the cycle a bit is accepted, the block writes the adapted probability to the requested index. For a 0 the new value is p + ((2^PROB_W - p) >> MOVE_W). For a 1 it is p - (p >> MOVE_W). Defaults are PROB_W = 11 and MOVE_W = 5.
- R8: A request holds its index and stays asserted until bit_ack. bit_prob equals the memory word at prob_addr. A bit is accepted in the cycle bit_req and bit_ack are both high, so requests can follow each other with no gap.
- R9: done is high for exactly one cycle, the cycle after the eighth accepted bit, with byte_out valid. The block is idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one literal (taken only when idle) |
| guided | input | 1 | 1 = steered by match_byte, 0 = plain tree |
| match_byte | input | 8 | Reference byte used in guided mode |
| base | input | ADDR_W | Start address of this literal's probability set |
| prob_addr | output | ADDR_W | Probability word address for the current bit |
| prob_rdata | input | PROB_W | Memory word at prob_addr (combinational read) |
| prob_we | output | 1 | Write strobe for the adapted probability |
| prob_wdata | output | PROB_W | Adapted probability |
| bit_req | output | 1 | Request to the decoder core for one bit |
| bit_prob | output | PROB_W | Probability handed to the decoder core |
| bit_ack | input | 1 | Core returns a bit this cycle |
| bit_val | input | 1 | Returned bit |
| done | output | 1 | One-cycle literal-complete pulse |
| byte_out | output | 8 | Decoded literal, valid with done |

## Verification
Two events share a cycle in this block. The adapted write for one bit happens in the same cycle as the offset update, which decides where the next bit reads. The bench drives this by answering each request in the cycle it appears. It checks every request address against its own reference walk of the match state, and it checks bit_prob against a shadow memory that already holds the earlier write-backs. Some literals also add stall cycles and a stray start while busy. The bench then confirms that the indices, the written memory and the byte are the same as the reference.

// File: rtl/mlit_pkg.sv
package mlit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BIT  = 2'd1,
    ST_DONE = 2'd2
  } mlit_state_e;

  // Offset mask survives only while decoded bit equals the match bit.
  function automatic logic [8:0] offset_after(input logic [8:0] off,
                                              input logic [8:0] mterm,
                                              input logic       b);
    return b ? (off & mterm) : (off & ~mterm);
  endfunction

  function automatic logic [8:0] symbol_after(input logic [8:0] sym,
                                              input logic       b);
    return {sym[7:0], b};
  endfunction

endpackage

// File: rtl/mlit_index.sv
module mlit_index #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [8:0]        offset,
  input  logic              ref_msb,
  input  logic [8:0]        symbol,
  output logic [8:0]        match_term,
  output logic [ADDR_W-1:0] index
);
  assign match_term = {offset[8] & ref_msb, 8'd0};
  assign index      = base + ADDR_W'(offset) + ADDR_W'(match_term) + ADDR_W'(symbol);
endmodule

// File: rtl/mlit_prob_adapt.sv
module mlit_prob_adapt #(
  parameter int unsigned PROB_W = 11,
  parameter int unsigned MOVE_W = 5
) (
  input  logic [PROB_W-1:0] p_in,
  input  logic              bit_in,
  output logic [PROB_W-1:0] p_out
);
  localparam logic [PROB_W:0] TOTAL = (PROB_W+1)'(1) << PROB_W;

  logic [PROB_W:0] headroom;
  logic [PROB_W:0] rise;
  logic [PROB_W:0] fall;

  always_comb begin
    headroom = TOTAL - {1'b0, p_in};
    rise     = headroom >> MOVE_W;
    fall     = {1'b0, p_in} >> MOVE_W;
    if (bit_in) p_out = p_in - PROB_W'(fall);
    else        p_out = p_in + PROB_W'(rise);
  end
endmodule

// File: rtl/mlit_decoder.sv
module mlit_decoder
  import mlit_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned PROB_W = 11,
  parameter int unsigned MOVE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              guided,
  input  logic [7:0]        match_byte,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] prob_addr,
  input  logic [PROB_W-1:0] prob_rdata,
  output logic              prob_we,
  output logic [PROB_W-1:0] prob_wdata,
  output logic              bit_req,
  output logic [PROB_W-1:0] bit_prob,
  input  logic              bit_ack,
  input  logic              bit_val,
  output logic              done,
  output logic [7:0]        byte_out
);
  localparam int unsigned     NBITS    = 8;
  localparam int unsigned     CNT_W    = $clog2(NBITS + 1);
  localparam logic [8:0]      OFF_INIT = 9'h100;
  localparam logic [ADDR_W-1:0] SET_SIZE = ADDR_W'(12'h300);

  mlit_state_e       state_q;
  logic [8:0]        sym_q;
  logic [8:0]        off_q;
  logic [7:0]        ref_q;
  logic [ADDR_W-1:0] base_q;
  logic              guided_q;
  logic [CNT_W-1:0]  cnt_q;

  // named internal events
  logic              accept_ev;
  logic              last_ev;
  logic              collapse_ev;
  logic [8:0]        match_term;
  logic [8:0]        off_next;
  logic [ADDR_W-1:0] idx;

  mlit_index #(.ADDR_W(ADDR_W)) u_index (
    .base       (base_q),
    .offset     (off_q),
    .ref_msb    (ref_q[7]),
    .symbol     (sym_q),
    .match_term (match_term),
    .index      (idx)
  );

  mlit_prob_adapt #(.PROB_W(PROB_W), .MOVE_W(MOVE_W)) u_adapt (
    .p_in   (prob_rdata),
    .bit_in (bit_val),
    .p_out  (prob_wdata)
  );

  assign bit_req     = (state_q == ST_BIT);
  assign accept_ev   = bit_req && bit_ack;
  assign last_ev     = accept_ev && (cnt_q == CNT_W'(NBITS - 1));
  assign off_next    = offset_after(off_q, match_term, bit_val);
  assign collapse_ev = accept_ev && (off_q != 9'd0) && (off_next == 9'd0);
  assign prob_addr   = idx;
  assign bit_prob    = prob_rdata;
  assign prob_we     = accept_ev;
  assign done        = (state_q == ST_DONE);
  assign byte_out    = sym_q[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sym_q    <= 9'd1;
      off_q    <= 9'd0;
      ref_q    <= 8'd0;
      base_q   <= '0;
      guided_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q  <= ST_BIT;
            sym_q    <= 9'd1;
            off_q    <= guided ? OFF_INIT : 9'd0;
            ref_q    <= match_byte;
            base_q   <= base;
            guided_q <= guided;
            cnt_q    <= '0;
          end
        end
        ST_BIT: begin
          if (accept_ev) begin
            sym_q <= symbol_after(sym_q, bit_val);
            off_q <= off_next;
            ref_q <= {ref_q[6:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
            if (last_ev) state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: nothing active in the first cycle out of reset
  p_idle_after_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!bit_req && !done && !prob_we));

  // R3: index stays inside the literal's probability set
  p_index_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |-> (ADDR_W'(prob_addr - base_q) < SET_SIZE));

  // R4: once the offset mask has collapsed it never comes back in this literal
  p_collapse_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && $past(bit_req) && ($past(off_q) == 9'd0)) |-> (off_q == 9'd0));

  // R4: a collapse happens only on a disagreeing bit
  p_collapse_on_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    collapse_ev |-> (bit_val != match_term[8]));

  // R5: plain mode addresses the forward tree directly
  p_plain_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && !guided_q) |-> (prob_addr == base_q + ADDR_W'(sym_q)));

  // R6: completion only after eight accepted bits
  p_eight_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt_q == CNT_W'(NBITS)));

  // R8: an unanswered request is held unchanged
  p_hold_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && !bit_ack) |=> (bit_req && $stable(prob_addr)));

  // R9: done is a single-cycle pulse followed by idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !bit_req));

endmodule

// File: tb/mlit_decoder_tb.sv
`timescale 1ns/1ps
module mlit_decoder_tb_top;
  localparam int AW = 11;
  localparam int PW = 11;
  localparam int MEMN = 1536;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, guided = 1'b0, bit_ack = 1'b0, bit_val = 1'b0;
  logic [7:0] match_byte = 8'd0;
  logic [AW-1:0] base = '0;
  logic [AW-1:0] prob_addr;
  logic [PW-1:0] prob_rdata, prob_wdata, bit_prob;
  logic prob_we, bit_req, done;
  logic [7:0] byte_out;

  logic [PW-1:0] mem [MEMN];
  int ref_mem [MEMN];
  int vectors = 0, miscompares = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mlit_decoder #(.ADDR_W(AW), .PROB_W(PW), .MOVE_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .guided(guided),
    .match_byte(match_byte), .base(base), .prob_addr(prob_addr),
    .prob_rdata(prob_rdata), .prob_we(prob_we), .prob_wdata(prob_wdata),
    .bit_req(bit_req), .bit_prob(bit_prob), .bit_ack(bit_ack),
    .bit_val(bit_val), .done(done), .byte_out(byte_out));

  assign prob_rdata = mem[prob_addr];
  always @(posedge clk) if (prob_we) mem[prob_addr] <= prob_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One literal: reference walk, then drive the core side and compare each cycle.
  task automatic run_lit(input bit g, input logic [7:0] mb, input int bs,
                         input logic [7:0] bits, input logic [7:0] stalls,
                         input bit poke);
    int exp_idx[8];
    int exp_p[8];
    int sym = 1;
    bit still = g;
    for (int k = 0; k < 8; k++) begin
      int rb = (mb >> (7 - k)) & 1;
      int b  = (bits >> (7 - k)) & 1;
      int ix = bs + sym;
      if (still) ix += 256 * (1 + rb);
      exp_idx[k] = ix;
      exp_p[k]   = ref_mem[ix];
      if (b == 0) ref_mem[ix] = ref_mem[ix] + (2048 - ref_mem[ix]) / 32;
      else        ref_mem[ix] = ref_mem[ix] - ref_mem[ix] / 32;
      if (still && b != rb) still = 0;
      sym = sym * 2 + b;
    end
    guided = g; match_byte = mb; base = AW'(bs); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (stalls[7 - k]) begin
        bit_ack = 1'b0;
        if (poke) begin start = 1'b1; guided = ~g; match_byte = ~mb; base = '0; end
        @(negedge clk);
        start = 1'b0;
        chk(bit_req && prob_addr == AW'(exp_idx[k]), "R8 held request", int'(prob_addr), exp_idx[k]);
      end
      chk(bit_req && prob_addr == AW'(exp_idx[k]), g ? "R3/R4 index" : "R5 index",
          int'(prob_addr), exp_idx[k]);
      chk(bit_prob == PW'(exp_p[k]), "R8 bit_prob", int'(bit_prob), exp_p[k]);
      bit_ack = 1'b1; bit_val = bits[7 - k];
      @(negedge clk);
    end
    bit_ack = 1'b0;
    chk(done === 1'b1, "R9 done", int'(done), 1);
    chk(byte_out == bits, "R6 byte", int'(byte_out), int'(bits));
    @(negedge clk);
    chk(done === 1'b0 && bit_req === 1'b0, "R9 single pulse", int'(done), 0);
    begin
      int bad = 0;
      for (int i = 0; i < MEMN; i++) if (int'(mem[i]) != ref_mem[i]) bad++;
      chk(bad == 0, "R7 memory", bad, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < MEMN; i++) begin
      mem[i] = PW'(64 + (i * 53) % 1900);
      ref_mem[i] = 64 + (i * 53) % 1900;
    end
    repeat (3) @(negedge clk);
    chk(!bit_req && !done && !prob_we, "R1 reset", int'({bit_req, done, prob_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bit_req && !done && !prob_we, "R1 idle", int'({bit_req, done, prob_we}), 0);
    run_lit(1'b1, 8'hA5, 0,     8'hA5, 8'h00, 1'b0); // R4 never collapses
    run_lit(1'b1, 8'h3C, 0,     8'hBC, 8'h00, 1'b0); // R4 first-bit mismatch
    run_lit(1'b1, 8'hF0, 0,     8'hF4, 8'h00, 1'b0); // R4 late mismatch
    run_lit(1'b0, 8'hFF, 0,     8'h5A, 8'h00, 1'b0); // R5 plain, match byte ignored
    run_lit(1'b1, 8'h81, 12'h300, 8'h80, 8'h24, 1'b1); // R2 start while busy, R8 stalls
    run_lit(1'b0, 8'h00, 12'h300, 8'hFF, 8'h81, 1'b1); // R2 R5 with stalls
    run_lit(1'b1, 8'h00, 12'h300, 8'h00, 8'h00, 1'b0); // R6 all zeros, R7 repeat words
    run_lit(1'b1, 8'h00, 0,     8'h00, 8'h00, 1'b0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++; miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule